// File: doc/BRIEF.md
# Shadow-backed SRAM with store and recall

The block holds a working SRAM array and a shadow array of the same size that stands in for nonvolatile storage. Both are register arrays. While idle, the working array answers a chip-enable / write-enable / output-enable port. The data bus is modelled as a split tri-state: an input bus, an output bus and an output-drive flag.

A store pulse copies the whole working image into the shadow. The copy is done in two sweeps: the first erases the shadow, the second programs it word by word. A recall pulse brings the shadow image back into the working array. It also takes two sweeps: the first clears the working array, the second loads it. The shadow array is never modified by a recall. For the whole transfer the external port is locked out and `busy_o` is high.

A debug write port lets a test environment seed the shadow array while the block is idle. The default size is 1K words. The address width is a parameter and can be raised to the full 8K.

Top module: `nv_shadow_sram`

## Requirements
- R1: With `busy_o` low, `ce_ni`=0, `oe_ni`=0 and `we_ni`=1, `dq_oe_o` is 1 and `dq_o` shows the working word at `addr_i` in the same cycle.
- R2: With `busy_o` low, `ce_ni`=0 and `we_ni`=0, `dq_i` is written to the working word at `addr_i` on the rising clock edge.
- R3: `dq_oe_o` is 0 whenever `ce_ni`=1 or `we_ni`=0, even if `oe_ni`=0.
- R4: After reset, every word of both arrays reads 0 and `busy_o` is 0.
- R5: A store replaces every shadow word with the working word at the same address. The working array is left unchanged. The shadow is erased before it is programmed.
- R6: A recall replaces every working word with the shadow word at the same address. Clearing comes before loading.
- R7: An accepted command raises `busy_o` from the next cycle. `busy_o` stays high for exactly 2*(2^ADDR_W + EXTRA_DLY) cycles, then the port is usable again.
- R8: While `busy_o` is high, these inputs have no effect and `dq_oe_o` is 0: port writes and reads, store and recall pulses, and debug writes.
- R9: A recall does not alter the shadow array, so repeated recalls give identical working contents.
- R10: If store and recall are requested in the same idle cycle, the store is performed and the recall is dropped.
- R11: With `busy_o` low, `dbg_we_i`=1 writes `dbg_data_i` to shadow word `dbg_addr_i` on the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| addr_i | input | ADDR_W | Word address |
| dq_i | input | DATA_W | Data bus, inbound |
| dq_o | output | DATA_W | Data bus, outbound |
| dq_oe_o | output | 1 | Outbound bus drive flag (0 = high impedance) |
| store_req_i | input | 1 | Store request pulse |
| recall_req_i | input | 1 | Recall request pulse |
| busy_o | output | 1 | Transfer in progress |
| dbg_we_i | input | 1 | Debug shadow write strobe |
| dbg_addr_i | input | ADDR_W | Debug shadow address |
| dbg_data_i | input | DATA_W | Debug shadow data |

## Verification
The shadow array cannot be read directly at the port. Every fact about it has to be brought back through a recall and a full read sweep of the working array.

The hardest case is showing that a store captured the image and that a recall left the shadow alone. To reach it, the stimulus runs a fixed series of steps:
1. Write one pattern and store it.
2. Overwrite the working array with a second pattern.
3. Recall, and sweep.
4. Recall again, and sweep again.

The bench repeats this kind of series with store and recall requested together, and with writes, reads, commands and debug writes thrown at the port while a transfer runs. The reference model is checked on every cycle, so a window of busy that is one cycle too long or too short also shows up.

// File: rtl/nv_pkg.sv
package nv_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ERASE,
    PH_PROG,
    PH_CLEAR,
    PH_LOAD
  } nv_phase_e;
endpackage

// File: rtl/nv_mem_array.sv
module nv_mem_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_a_i,
  output logic [DATA_W-1:0] rdata_a_o,
  input  logic [ADDR_W-1:0] raddr_b_i,
  output logic [DATA_W-1:0] rdata_b_o
);
  localparam int Depth = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [Depth];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < Depth; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];
endmodule

// File: rtl/nv_xfer_ctrl.sv
module nv_xfer_ctrl
  import nv_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int EXTRA_DLY = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              store_req_i,
  input  logic              recall_req_i,
  output nv_phase_e         phase_o,
  output logic [ADDR_W-1:0] idx_o,
  output logic              step_o,
  output logic              busy_o
);
  localparam int Depth = 1 << ADDR_W;
  localparam int PhLen = Depth + EXTRA_DLY;
  localparam int CntW  = $clog2(PhLen + 1);
  localparam logic [CntW-1:0] LastCnt  = CntW'(PhLen - 1);
  localparam logic [CntW-1:0] DepthCnt = CntW'(Depth);

  nv_phase_e       phase_q;
  logic [CntW-1:0] cnt_q;
  logic            last;

  assign last = (cnt_q == LastCnt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          cnt_q <= '0;
          if (store_req_i)       phase_q <= PH_ERASE;  // store has priority
          else if (recall_req_i) phase_q <= PH_CLEAR;
        end
        PH_ERASE, PH_PROG, PH_CLEAR, PH_LOAD: begin
          if (last) begin
            cnt_q <= '0;
            case (phase_q)
              PH_ERASE: phase_q <= PH_PROG;
              PH_CLEAR: phase_q <= PH_LOAD;
              default:  phase_q <= PH_IDLE;
            endcase
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o = phase_q;
  assign idx_o   = cnt_q[ADDR_W-1:0];
  assign step_o  = (phase_q != PH_IDLE) && (cnt_q < DepthCnt);
  assign busy_o  = (phase_q != PH_IDLE);
endmodule

// File: rtl/nv_shadow_sram.sv
module nv_shadow_sram
  import nv_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 8,
  parameter int EXTRA_DLY = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o,
  input  logic              store_req_i,
  input  logic              recall_req_i,
  output logic              busy_o,
  input  logic              dbg_we_i,
  input  logic [ADDR_W-1:0] dbg_addr_i,
  input  logic [DATA_W-1:0] dbg_data_i
);
  nv_phase_e         phase;
  logic [ADDR_W-1:0] idx;
  logic              step;
  logic              busy;

  logic              wk_we, sh_we;
  logic [ADDR_W-1:0] wk_waddr, sh_waddr;
  logic [DATA_W-1:0] wk_wdata, sh_wdata;
  logic [DATA_W-1:0] wk_port_rd, wk_idx_rd, sh_idx_rd, sh_unused_rd;

  nv_xfer_ctrl #(
    .ADDR_W   (ADDR_W),
    .EXTRA_DLY(EXTRA_DLY)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .store_req_i (store_req_i),
    .recall_req_i(recall_req_i),
    .phase_o     (phase),
    .idx_o       (idx),
    .step_o      (step),
    .busy_o      (busy)
  );

  // working array: engine owns it during clear/load, port otherwise
  always_comb begin
    wk_we    = 1'b0;
    wk_waddr = addr_i;
    wk_wdata = dq_i;
    if (phase == PH_CLEAR || phase == PH_LOAD) begin
      wk_we    = step;
      wk_waddr = idx;
      wk_wdata = (phase == PH_LOAD) ? sh_idx_rd : '0;
    end else if (!busy) begin
      wk_we = !ce_ni && !we_ni;
    end
  end

  // shadow array: engine owns it during erase/program, debug port when idle
  always_comb begin
    sh_we    = 1'b0;
    sh_waddr = dbg_addr_i;
    sh_wdata = dbg_data_i;
    if (phase == PH_ERASE || phase == PH_PROG) begin
      sh_we    = step;
      sh_waddr = idx;
      sh_wdata = (phase == PH_PROG) ? wk_idx_rd : '0;
    end else if (!busy) begin
      sh_we = dbg_we_i;
    end
  end

  nv_mem_array #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_work (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (wk_we),
    .waddr_i  (wk_waddr),
    .wdata_i  (wk_wdata),
    .raddr_a_i(addr_i),
    .rdata_a_o(wk_port_rd),
    .raddr_b_i(idx),
    .rdata_b_o(wk_idx_rd)
  );

  nv_mem_array #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_shadow (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (sh_we),
    .waddr_i  (sh_waddr),
    .wdata_i  (sh_wdata),
    .raddr_a_i(idx),
    .rdata_a_o(sh_idx_rd),
    .raddr_b_i(dbg_addr_i),
    .rdata_b_o(sh_unused_rd)
  );

  assign dq_oe_o = !busy && !ce_ni && !oe_ni && we_ni;
  assign dq_o    = wk_port_rd;
  assign busy_o  = busy;
endmodule

// File: rtl/nv_shadow_sram_chk.sv
module nv_shadow_sram_chk
  import nv_pkg::*;
(
  input logic      clk_i,
  input logic      rst_ni,
  input logic      ce_ni,
  input logic      we_ni,
  input logic      oe_ni,
  input logic      store_req_i,
  input logic      recall_req_i,
  input logic      busy_o,
  input logic      dq_oe_o,
  input nv_phase_e phase_i
);
  assert_drive_gate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> (!ce_ni && !oe_ni && we_ni));

  assert_lockout_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !dq_oe_o);

  assert_start_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(store_req_i || recall_req_i));

  assert_store_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(busy_o) && $past(store_req_i)) |-> (phase_i == PH_ERASE));

  assert_recall_clears_first_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(busy_o) && !$past(store_req_i)) |-> (phase_i == PH_CLEAR));

  assert_ends_after_fill_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> ($past(phase_i) == PH_PROG || $past(phase_i) == PH_LOAD));
endmodule

bind nv_shadow_sram nv_shadow_sram_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ce_ni       (ce_ni),
  .we_ni       (we_ni),
  .oe_ni       (oe_ni),
  .store_req_i (store_req_i),
  .recall_req_i(recall_req_i),
  .busy_o      (busy_o),
  .dq_oe_o     (dq_oe_o),
  .phase_i     (phase)
);

// File: tb/nv_shadow_sram_bench.sv
module nv_shadow_sram_bench;
  localparam int AW    = 10;
  localparam int DW    = 8;
  localparam int EXTRA = 3;
  localparam int DEPTH = 1 << AW;
  localparam int BUSY_LEN = 2 * (DEPTH + EXTRA);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ce_ni = 1'b1, we_ni = 1'b1, oe_ni = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dq_i = '0;
  logic [DW-1:0] dq_o;
  logic dq_oe_o, busy_o;
  logic store_req = 1'b0, recall_req = 1'b0;
  logic dbg_we = 1'b0;
  logic [AW-1:0] dbg_addr = '0;
  logic [DW-1:0] dbg_data = '0;

  int n_checks = 0;
  int n_err = 0;
  string cur = "R4";

  always #5 clk = ~clk;

  nv_shadow_sram #(.ADDR_W(AW), .DATA_W(DW), .EXTRA_DLY(EXTRA)) u_nv_shadow_sram (
    .clk_i(clk), .rst_ni(rst_ni), .ce_ni(ce_ni), .we_ni(we_ni), .oe_ni(oe_ni),
    .addr_i(addr), .dq_i(dq_i), .dq_o(dq_o), .dq_oe_o(dq_oe_o),
    .store_req_i(store_req), .recall_req_i(recall_req), .busy_o(busy_o),
    .dbg_we_i(dbg_we), .dbg_addr_i(dbg_addr), .dbg_data_i(dbg_data)
  );

  // behavioural reference model
  logic [DW-1:0] m_work [DEPTH];
  logic [DW-1:0] m_shadow [DEPTH];
  int busy_cnt = 0;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) begin
        m_work[i] = '0;
        m_shadow[i] = '0;
      end
      busy_cnt = 0;
    end else if (busy_cnt > 0) begin
      busy_cnt = busy_cnt - 1;
    end else begin
      if (!ce_ni && !we_ni) m_work[addr] = dq_i;
      if (dbg_we) m_shadow[dbg_addr] = dbg_data;
      if (store_req) m_shadow = m_work;
      else if (recall_req) m_work = m_shadow;
      if (store_req || recall_req) busy_cnt = BUSY_LEN;
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_ni) begin
      logic exp_busy, exp_oe;
      exp_busy = (busy_cnt > 0);
      exp_oe = !exp_busy && !ce_ni && !oe_ni && we_ni;
      n_checks++;
      if (busy_o !== exp_busy) begin
        n_err++;
        $display("FAIL %s (R7) busy_o act %0b exp %0b", cur, busy_o, exp_busy);
      end
      n_checks++;
      if (dq_oe_o !== exp_oe) begin
        n_err++;
        $display("FAIL %s (R3) dq_oe_o act %0b exp %0b", cur, dq_oe_o, exp_oe);
      end
      if (exp_oe) begin
        n_checks++;
        if (dq_o !== m_work[addr]) begin
          n_err++;
          $display("FAIL %s (R1) dq_o[%0d] act %0h exp %0h", cur, addr, dq_o, m_work[addr]);
        end
      end
    end
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic quiet();
    ce_ni = 1'b1; we_ni = 1'b1; oe_ni = 1'b1;
    store_req = 1'b0; recall_req = 1'b0; dbg_we = 1'b0;
  endtask

  task automatic wr(input int a, input int d, input logic oe);
    ce_ni = 1'b0; we_ni = 1'b0; oe_ni = oe; addr = AW'(a); dq_i = DW'(d);
    tick();
    quiet();
  endtask

  task automatic sweep();
    for (int a = 0; a < DEPTH; a++) begin
      ce_ni = 1'b0; we_ni = 1'b1; oe_ni = 1'b0; addr = AW'(a);
      tick();
    end
    quiet();
  endtask

  task automatic fill(input int mul, input int add);
    for (int a = 0; a < DEPTH; a++) wr(a, a * mul + add, 1'b1);
  endtask

  task automatic cmd(input logic st, input logic rc);
    store_req = st; recall_req = rc;
    tick();
    quiet();
  endtask

  task automatic wait_idle();
    while (busy_cnt > 0) tick();
    tick();
  endtask

  initial begin
    quiet();
    repeat (3) tick();
    rst_ni = 1'b1;
    tick();

    cur = "R4";  // both arrays zero after reset
    sweep();
    cmd(1'b0, 1'b1); wait_idle(); sweep();  // shadow also zero

    cur = "R2";
    fill(3, 1);
    cur = "R1";
    sweep();

    cur = "R3";  // we low with oe low: no drive; ce high: no drive
    wr(5, 8'h5a, 1'b0);
    ce_ni = 1'b1; we_ni = 1'b1; oe_ni = 1'b0; addr = AW'(5); tick(); quiet();
    ce_ni = 1'b0; oe_ni = 1'b0; addr = AW'(5); tick(); quiet();

    cur = "R11";  // seed shadow, then recall to expose it
    for (int a = 0; a < DEPTH; a += 7) begin
      dbg_we = 1'b1; dbg_addr = AW'(a); dbg_data = DW'(a ^ 8'hc3); tick();
    end
    quiet();
    cur = "R6";
    cmd(1'b0, 1'b1); wait_idle(); sweep();

    cur = "R8";  // traffic during a transfer
    fill(5, 2);
    cmd(1'b1, 1'b0);
    repeat (20) begin
      ce_ni = 1'b0; we_ni = 1'b0; oe_ni = 1'b0; addr = AW'(9); dq_i = 8'hee;
      dbg_we = 1'b1; dbg_addr = AW'(9); dbg_data = 8'h77;
      recall_req = 1'b1; tick();
      ce_ni = 1'b0; we_ni = 1'b1; oe_ni = 1'b0; dbg_we = 1'b0; recall_req = 1'b0;
      store_req = 1'b1; tick();
    end
    quiet();
    wait_idle();
    sweep();

    cur = "R5";  // stored image survives overwrite, comes back on recall
    fill(11, 9);
    cmd(1'b0, 1'b1); wait_idle(); sweep();
    cur = "R9";
    fill(13, 4);
    cmd(1'b0, 1'b1); wait_idle(); sweep();
    cmd(1'b0, 1'b1); wait_idle(); sweep();

    cur = "R10";  // store wins over recall
    fill(17, 6);
    cmd(1'b1, 1'b1); wait_idle(); sweep();
    fill(2, 0);
    cmd(1'b0, 1'b1); wait_idle(); sweep();

    cur = "R7";  // write in accept cycle, then back-to-back command
    ce_ni = 1'b0; we_ni = 1'b0; addr = AW'(3); dq_i = 8'h3c; store_req = 1'b1; tick();
    quiet();
    wait_idle();
    cmd(1'b0, 1'b1); wait_idle(); sweep();

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog (R7) act timeout exp completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule